// File: doc/BRIEF.md
# NAND Host Bridge

This block sits between a 16-bit register-mapped host bus and an 8-bit NAND device. The host writes whole coded bytes into a mode register. The code picks the kind of cycle that follows (command, address or data) and sets the chip-enable, CLE, ALE, write-permission and power-enable lines. Every access to the data port moves a full host word. In data mode that word is split into two NAND bytes, each with its own write strobe. In command or address mode only the low byte goes out, as a single latched cycle. A read of the data port gathers two NAND bytes into one word, with the first byte in the low half.

A status register shows the device ready/busy line after it has been synchronised. An interrupt-status and mask pair records a ready request when that line rises, and drives a level interrupt. While a multi-beat transfer is in progress the bridge raises `hostBusy`, and it ignores any host access made in that time. Read results come back on `hostRData` together with a one-cycle `hostRValid` pulse.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the mode register reads 0, the chip enable is inactive (`nandCeN`=1), both strobes are high, the I/O driver is off, and `irq`, `hostBusy`, `nandPwrEn` and `hostRValid` are all 0.
- R2: The mode register is at address 1 and reads back all 8 bits. Its bit 4 drives the chip enable (`nandCeN` = not bit 4). Bit 0 drives CLE and bit 1 drives ALE, each only while bit 4 is set. Bit 2 drives `nandPwrEn`. A mode write by itself produces no strobe.
- R3: In data mode (bits 4 and 7 set, bits 0 and 1 clear, for example 0x94), a host write to the data port (address 0) produces two one-cycle low pulses on `nandWeN`, low byte first, separated by one cycle with `nandWeN` high. `nandIoOe` is high during both pulses and low once the transfer ends.
- R4: In command mode (0x95) or address mode (0x96), a data-port write produces exactly one write pulse, carrying the low byte, with CLE or ALE high respectively.
- R5: A data-port write while mode bit 4 or bit 7 is clear produces no write pulse.
- R6: With bit 4 set, a data-port read produces two `nandReN` pulses. The byte captured during the first pulse is returned in bits 7:0 and the second in bits 15:8, with `hostRValid` pulsing.
- R7: A data-port read while bit 4 is clear returns 0 and produces no read pulse.
- R8: The status register (address 2) reads 0x80 while `nandRb` is low (busy) and 0x00 while it is high, after the synchroniser delay.
- R9: A rising edge of `nandRb` sets bit 0 of the interrupt-status register (address 3). A falling edge sets nothing.
- R10: Interrupt-status bits stay set until they are written with 1. Writing 0 to a bit leaves it unchanged, and writing 0x0F clears all of them.
- R11: `irq` is the OR of interrupt-status bits 3:0 ANDed with mask bits 3:0 (mask at address 4). Writing 0x81 enables the ready interrupt and writing 0x00 disables it.
- R12: `hostBusy` is high while a data transfer is running, and any host access made during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register address |
| hostWr | input | 1 | Write request, one cycle |
| hostRd | input | 1 | Read request, one cycle |
| hostWData | input | 16 | Write data |
| hostRData | output | 16 | Read data |
| hostRValid | output | 1 | Read data valid pulse |
| hostBusy | output | 1 | Transfer in progress; requests ignored |
| nandIoOut | output | 8 | NAND I/O output byte |
| nandIoIn | input | 8 | NAND I/O input byte |
| nandIoOe | output | 1 | NAND I/O output enable |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandRb | input | 1 | Ready (1) / busy (0) |
| nandPwrEn | output | 1 | Device power enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bridge with its defaults: a 16-bit host word, 8-bit NAND bytes and a two-stage ready/busy synchroniser. With two lanes per word, every lane order and every strobe/gap pattern can be observed. With an 8-bit mode register, all 256 mode codes can be swept and the chip-enable, CLE, ALE and power outputs checked arithmetically against each code. The short synchroniser keeps edge-to-event latency within a few cycles, so rising and falling ready edges, write-one-to-clear and mask gating can each be exercised in isolation.

// File: rtl/nandhost_pkg.sv
package nandhost_pkg;

  // register address map
  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_MODE  = 3'd1;
  localparam logic [2:0] ADDR_STAT  = 3'd2;
  localparam logic [2:0] ADDR_ISTAT = 3'd3;
  localparam logic [2:0] ADDR_IMASK = 3'd4;

  // mode register bit positions
  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_PWR = 2;
  localparam int MB_CE  = 4;
  localparam int MB_WE  = 7;

  // strobes from the sequencer to the datapath and pins
  typedef struct packed {
    logic regWr;     // register write accepted
    logic regRd;     // register read accepted (immediate reply)
    logic loadWr;    // latch host word for an outgoing transfer
    logic drive;     // I/O driver enabled
    logic weLow;     // write strobe active
    logic reLow;     // read strobe active
    logic capture;   // sample the NAND byte for the current lane
    logic readDone;  // final lane captured, reply this cycle
  } seqStrb_t;

endpackage

// File: rtl/nandhost_ctrl.sv
module nandhost_ctrl
  import nandhost_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BEAT_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [2:0]        hostAddr,
  input  logic              modeCe,
  input  logic              modeWe,
  input  logic              modeNarrow,
  output logic              busy,
  output seqStrb_t          strb,
  output logic [BEAT_W-1:0] beat
);

  typedef enum logic [1:0] {S_IDLE, S_STB, S_GAP} seq_e;

  localparam logic [BEAT_W-1:0] LAST_FULL = BEAT_W'(LANES - 1);

  seq_e              state;
  logic              isRead;
  logic [BEAT_W-1:0] lastBeat;
  logic              idle;
  logic              isData;
  logic              startWr;
  logic              startRd;

  assign idle    = (state == S_IDLE);
  assign isData  = (hostAddr == ADDR_DATA);
  assign startWr = idle && hostWr && isData && modeCe && modeWe;
  assign startRd = idle && !hostWr && hostRd && isData && modeCe;
  assign busy    = !idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      beat     <= '0;
      isRead   <= 1'b0;
      lastBeat <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (startWr) begin
            state    <= S_STB;
            beat     <= '0;
            isRead   <= 1'b0;
            lastBeat <= modeNarrow ? '0 : LAST_FULL;
          end else if (startRd) begin
            state    <= S_STB;
            beat     <= '0;
            isRead   <= 1'b1;
            lastBeat <= LAST_FULL;
          end
        end
        S_STB: begin
          if (beat == lastBeat) state <= S_IDLE;
          else                  state <= S_GAP;
        end
        S_GAP: begin
          state <= S_STB;
          beat  <= beat + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.regWr    = idle && hostWr && !isData;
    strb.regRd    = idle && !hostWr && hostRd && !(isData && modeCe);
    strb.loadWr   = startWr;
    strb.drive    = !idle && !isRead;
    strb.weLow    = (state == S_STB) && !isRead;
    strb.reLow    = (state == S_STB) && isRead;
    strb.capture  = (state == S_STB) && isRead;
    strb.readDone = (state == S_STB) && isRead && (beat == lastBeat);
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.weLow && strb.reLow));
  // R3
  we_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.weLow |=> !strb.weLow);
  // R6
  re_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reLow |=> !strb.reLow);
  // R5
  we_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.weLow |-> (modeCe && modeWe));

endmodule

// File: rtl/nandhost_dp.sv
module nandhost_dp
  import nandhost_pkg::*;
#(
  parameter int HOST_W      = 16,
  parameter int NAND_W      = 8,
  parameter int LANES       = HOST_W / NAND_W,
  parameter int BEAT_W      = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int SYNC_STAGES = 2,
  parameter int ISTAT_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWData,
  input  seqStrb_t          strb,
  input  logic [BEAT_W-1:0] beat,
  input  logic [NAND_W-1:0] nandIoIn,
  input  logic              nandRb,
  output logic [7:0]        modeReg,
  output logic [NAND_W-1:0] nandIoOut,
  output logic [HOST_W-1:0] hostRData,
  output logic              hostRValid,
  output logic              irq
);

  logic [7:0]             maskReg;
  logic [ISTAT_W-1:0]     istat;
  logic [ISTAT_W-1:0]     clrVec;
  logic [ISTAT_W-1:0]     setVec;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rbSync;
  logic                   rbPrev;
  logic                   rbRise;
  logic [HOST_W-1:0]      wrBuf;
  logic [HOST_W-1:0]      rdBuf;
  logic [HOST_W-1:0]      rdNext;
  logic [HOST_W-1:0]      regView;
  logic [NAND_W-1:0]      wrLane [LANES];

  // lane slicing for both directions
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrLane[g] = wrBuf[g*NAND_W +: NAND_W];
    assign rdNext[g*NAND_W +: NAND_W] =
      (strb.capture && beat == BEAT_W'(g)) ? nandIoIn : rdBuf[g*NAND_W +: NAND_W];
  end

  assign nandIoOut = wrLane[beat];

  // ready/busy synchroniser, idle value is "ready"
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '1;
      rbPrev    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], nandRb};
      rbPrev    <= rbSync;
    end
  end

  assign rbSync = syncChain[SYNC_STAGES-1];
  assign rbRise = rbSync && !rbPrev;

  assign setVec = {{(ISTAT_W-1){1'b0}}, rbRise};
  assign clrVec = (strb.regWr && hostAddr == ADDR_ISTAT) ? hostWData[ISTAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      maskReg <= '0;
      istat   <= '0;
    end else begin
      if (strb.regWr && hostAddr == ADDR_MODE)  modeReg <= hostWData[7:0];
      if (strb.regWr && hostAddr == ADDR_IMASK) maskReg <= hostWData[7:0];
      istat <= (istat & ~clrVec) | setVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBuf <= '0;
      rdBuf <= '0;
    end else begin
      if (strb.loadWr)  wrBuf <= hostWData;
      if (strb.capture) rdBuf <= rdNext;
    end
  end

  always_comb begin
    unique case (hostAddr)
      ADDR_MODE:  regView = HOST_W'(modeReg);
      ADDR_STAT:  regView = HOST_W'({!rbSync, 7'b0});
      ADDR_ISTAT: regView = HOST_W'(istat);
      ADDR_IMASK: regView = HOST_W'(maskReg);
      default:    regView = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRData  <= '0;
      hostRValid <= 1'b0;
    end else begin
      hostRValid <= strb.regRd || strb.readDone;
      if (strb.readDone)   hostRData <= rdNext;
      else if (strb.regRd) hostRData <= regView;
    end
  end

  assign irq = |(istat & maskReg[ISTAT_W-1:0]);

  // R9
  ready_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    rbRise |=> istat[0]);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (istat[0] && !(strb.regWr && hostAddr == ADDR_ISTAT && hostWData[0])) |=> istat[0]);
  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(modeReg));

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nandhost_pkg::*;
#(
  parameter int HOST_W      = 16,
  parameter int NAND_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [HOST_W-1:0] hostWData,
  output logic [HOST_W-1:0] hostRData,
  output logic              hostRValid,
  output logic              hostBusy,
  output logic [NAND_W-1:0] nandIoOut,
  input  logic [NAND_W-1:0] nandIoIn,
  output logic              nandIoOe,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  input  logic              nandRb,
  output logic              nandPwrEn,
  output logic              irq
);

  localparam int LANES  = HOST_W / NAND_W;
  localparam int BEAT_W = (LANES > 1) ? $clog2(LANES) : 1;

  seqStrb_t          strb;
  logic [BEAT_W-1:0] beat;
  logic [7:0]        modeReg;

  nandhost_ctrl #(.LANES(LANES), .BEAT_W(BEAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostAddr   (hostAddr),
    .modeCe     (modeReg[MB_CE]),
    .modeWe     (modeReg[MB_WE]),
    .modeNarrow (modeReg[MB_CLE] | modeReg[MB_ALE]),
    .busy       (hostBusy),
    .strb       (strb),
    .beat       (beat)
  );

  nandhost_dp #(
    .HOST_W(HOST_W), .NAND_W(NAND_W), .LANES(LANES),
    .BEAT_W(BEAT_W), .SYNC_STAGES(SYNC_STAGES), .ISTAT_W(4)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddr   (hostAddr),
    .hostWData  (hostWData),
    .strb       (strb),
    .beat       (beat),
    .nandIoIn   (nandIoIn),
    .nandRb     (nandRb),
    .modeReg    (modeReg),
    .nandIoOut  (nandIoOut),
    .hostRData  (hostRData),
    .hostRValid (hostRValid),
    .irq        (irq)
  );

  assign nandCeN   = !modeReg[MB_CE];
  assign nandCle   = modeReg[MB_CE] && modeReg[MB_CLE];
  assign nandAle   = modeReg[MB_CE] && modeReg[MB_ALE];
  assign nandPwrEn = modeReg[MB_PWR];
  assign nandWeN   = !strb.weLow;
  assign nandReN   = !strb.reLow;
  assign nandIoOe  = strb.drive;

endmodule

// File: tb/nand_host_bridge_test.sv
`timescale 1ns/1ps
module nand_host_bridge_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [15:0] hostWData = '0;
  logic [15:0] hostRData;
  logic        hostRValid, hostBusy;
  logic [7:0]  nandIoOut;
  logic [7:0]  nandIoIn = '0;
  logic        nandIoOe, nandCeN, nandCle, nandAle, nandWeN, nandReN;
  logic        nandRb = 1'b1;
  logic        nandPwrEn, irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] wrLog  [0:15];
  logic       cleLog [0:15];
  logic       aleLog [0:15];
  logic       oeLog  [0:15];
  int  wrCnt = 0;
  int  rdCnt = 0;
  int  gapErr = 0;
  logic [7:0] rdSeed = '0;
  logic prevWeLow = 1'b0;

  always #2.5 clk = ~clk;

  nand_host_bridge uut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWData(hostWData), .hostRData(hostRData), .hostRValid(hostRValid),
    .hostBusy(hostBusy), .nandIoOut(nandIoOut), .nandIoIn(nandIoIn),
    .nandIoOe(nandIoOe), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandRb(nandRb),
    .nandPwrEn(nandPwrEn), .irq(irq)
  );

  // NAND-side monitor and read responder
  always @(negedge clk) begin
    if (rstN) begin
      if (!nandWeN) begin
        if (wrCnt < 16) begin
          wrLog[wrCnt]  = nandIoOut;
          cleLog[wrCnt] = nandCle;
          aleLog[wrCnt] = nandAle;
          oeLog[wrCnt]  = nandIoOe;
        end
        wrCnt++;
        if (prevWeLow) gapErr++;
      end
      prevWeLow = !nandWeN;
      if (!nandReN) begin
        nandIoIn = rdSeed + 8'(rdCnt);
        rdCnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
    while (hostBusy) @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    while (!hostRValid) @(negedge clk);
    d = hostRData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ceN", 32'(nandCeN), 1);
    chk("R1 weN", 32'(nandWeN), 1);
    chk("R1 reN", 32'(nandReN), 1);
    chk("R1 oe", 32'(nandIoOe), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 busy", 32'(hostBusy), 0);
    chk("R1 pwr", 32'(nandPwrEn), 0);
    chk("R1 rvalid", 32'(hostRValid), 0);
    hread(3'd1, rd);
    chk("R1 mode", 32'(rd), 0);

    // R2 sweep of all mode codes
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mv;
      mv = 8'(m);
      hwrite(3'd1, 16'(mv));
      chk("R2 ceN", 32'(nandCeN), 32'(!mv[4]));
      chk("R2 cle", 32'(nandCle), 32'(mv[4] & mv[0]));
      chk("R2 ale", 32'(nandAle), 32'(mv[4] & mv[1]));
      chk("R2 pwr", 32'(nandPwrEn), 32'(mv[2]));
      if (m % 17 == 0) begin
        hread(3'd1, rd);
        chk("R2 readback", 32'(rd), 32'(mv));
      end
    end
    chk("R2 no strobe from mode writes", 32'(wrCnt), 0);

    // R3 data-mode writes
    hwrite(3'd1, 16'h0094);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] w;
      w = (i == 0) ? 16'h1234 : (i == 1) ? 16'hA55A : (i == 2) ? 16'h00FF : 16'hFF00;
      wrCnt = 0;
      hwrite(3'd0, w);
      chk("R3 strobe count", 32'(wrCnt), 2);
      chk("R3 first byte", 32'(wrLog[0]), 32'(w[7:0]));
      chk("R3 second byte", 32'(wrLog[1]), 32'(w[15:8]));
      chk("R3 cle/ale low", 32'({cleLog[0], aleLog[0], cleLog[1], aleLog[1]}), 0);
      chk("R3 oe during", 32'({oeLog[0], oeLog[1]}), 3);
      chk("R3 oe after", 32'(nandIoOe), 0);
    end
    chk("R3 gap between strobes", 32'(gapErr), 0);

    // R4 command and address modes
    hwrite(3'd1, 16'h0095);
    wrCnt = 0;
    hwrite(3'd0, 16'h12FF);
    chk("R4 cmd count", 32'(wrCnt), 1);
    chk("R4 cmd byte", 32'(wrLog[0]), 32'h00FF);
    chk("R4 cmd cle/ale", 32'({cleLog[0], aleLog[0]}), 2);
    hwrite(3'd1, 16'h0096);
    wrCnt = 0;
    hwrite(3'd0, 16'hBE34);
    chk("R4 addr count", 32'(wrCnt), 1);
    chk("R4 addr byte", 32'(wrLog[0]), 32'h0034);
    chk("R4 addr cle/ale", 32'({cleLog[0], aleLog[0]}), 1);

    // R5 gated writes
    for (int i = 0; i < 3; i++) begin
      logic [7:0] mv;
      mv = (i == 0) ? 8'h14 : (i == 1) ? 8'h80 : 8'h00;
      hwrite(3'd1, 16'(mv));
      wrCnt = 0;
      hwrite(3'd0, 16'hC3C3);
      repeat (4) @(negedge clk);
      chk("R5 no strobe", 32'(wrCnt), 0);
    end

    // R6 data reads
    hwrite(3'd1, 16'h0094);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] s;
      s = (i == 0) ? 8'h10 : (i == 1) ? 8'h7F : 8'hFF;
      rdSeed = s; rdCnt = 0;
      hread(3'd0, rd);
      chk("R6 read word", 32'(rd), 32'({s + 8'd1, s}));
      chk("R6 read strobes", 32'(rdCnt), 2);
    end

    // R7 read with chip enable off
    hwrite(3'd1, 16'h0000);
    rdCnt = 0;
    hread(3'd0, rd);
    chk("R7 data", 32'(rd), 0);
    chk("R7 strobes", 32'(rdCnt), 0);

    // R8 status, R9 ready edge
    hwrite(3'd3, 16'h000F);
    nandRb = 1'b0;
    repeat (5) @(negedge clk);
    hread(3'd2, rd);
    chk("R8 busy", 32'(rd), 32'h80);
    hread(3'd3, rd);
    chk("R9 no event on fall", 32'(rd), 0);
    nandRb = 1'b1;
    repeat (5) @(negedge clk);
    hread(3'd2, rd);
    chk("R8 ready", 32'(rd), 0);
    hread(3'd3, rd);
    chk("R9 event on rise", 32'(rd), 1);

    // R10 write-one-to-clear
    hwrite(3'd3, 16'h000E);
    hread(3'd3, rd);
    chk("R10 zero write keeps", 32'(rd), 1);
    hwrite(3'd3, 16'h000F);
    hread(3'd3, rd);
    chk("R10 clear", 32'(rd), 0);

    // R11 mask and irq
    hwrite(3'd4, 16'h0081);
    chk("R11 idle irq", 32'(irq), 0);
    nandRb = 1'b0; repeat (5) @(negedge clk);
    nandRb = 1'b1; repeat (5) @(negedge clk);
    chk("R11 irq on", 32'(irq), 1);
    hwrite(3'd4, 16'h0000);
    chk("R11 masked", 32'(irq), 0);
    hwrite(3'd4, 16'h0081);
    chk("R11 unmasked", 32'(irq), 1);
    hwrite(3'd3, 16'h000F);
    chk("R11 cleared", 32'(irq), 0);

    // R12 access during a transfer is ignored
    hwrite(3'd1, 16'h0094);
    wrCnt = 0;
    @(negedge clk);
    hostAddr = 3'd0; hostWData = 16'hABCD; hostWr = 1'b1;
    @(negedge clk);
    chk("R12 busy", 32'(hostBusy), 1);
    hostAddr = 3'd1; hostWData = 16'h0000;
    @(negedge clk);
    hostWr = 1'b0;
    while (hostBusy) @(negedge clk);
    hread(3'd1, rd);
    chk("R12 mode unchanged", 32'(rd), 32'h94);
    chk("R12 strobes", 32'(wrCnt), 2);
    chk("R12 bytes", 32'({wrLog[1], wrLog[0]}), 32'hABCD);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule